// File: doc/BRIEF.md
# Parallel Result Readout Port

This block drives a conversion result onto a 16-bit host data bus. The host reads the word by pulling both an active-low chip-select and an active-low read strobe low. The two strobes are OR-combined, so the bus is released while either one is high. High impedance is modelled with a per-bit output-enable vector beside the data, and the data bits are zero whenever they are not enabled. The port only responds when the mode select picks parallel operation. In serial mode it stays released whatever the strobes do.

The conversion sequencer provides a busy flag and the word it is converting. The block publishes that word into its own result register on the clock edge where busy is first seen low. A read made while busy is high therefore returns the previous result, and a read made after busy falls returns the fresh one.

At the start of each read, the published word is captured into a holding register, so a result update in the middle of a read cannot tear the word. The coding choice (straight binary, or twos complement by inverting the top bit) is applied at that capture. A byte-swap input exchanges the two byte lanes at the output. An 8-bit host can wire it to an address line and fetch both halves on one lane.

Top module: `par_readout`

## Requirements
- R1: After reset, oe_o is all zeros and data_o is all zeros.
- R2: One clock edge after cs_ni and rd_ni are both sampled low with ser_mode_i low, oe_o is all ones. One edge after either strobe is sampled high, oe_o is all zeros.
- R3: While ser_mode_i is sampled high, oe_o stays all zeros on the next cycle regardless of cs_ni and rd_ni.
- R4: With swap_i low during a read, data_o[7:0] carries the low byte of the captured word and data_o[15:8] carries the high byte.
- R5: With swap_i high during a read, data_o[15:8] carries the low byte and data_o[7:0] the high byte. A change of swap_i in the middle of a read takes effect at once without a new capture.
- R6: If twos_i is high at the capture edge, the word read has bit 15 inverted relative to the straight-binary result; if low, the word is passed unchanged. A later change of twos_i within the same read has no effect.
- R7: The published result loads conv_data_i on the edge where busy_i is sampled low after having been sampled high; it holds its value on every other edge.
- R8: A read that begins while busy_i is high returns the previously published result.
- R9: A read whose first edge coincides with the busy falling edge returns the new conv_data_i word.
- R10: While a read stays active and swap_i is unchanged, data_o does not change, even if a new result is published.
- R11: data_o is all zeros whenever oe_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip-select |
| rd_ni | input | 1 | Active-low read strobe |
| ser_mode_i | input | 1 | High selects serial mode and disables the parallel bus |
| swap_i | input | 1 | High exchanges the two byte lanes |
| twos_i | input | 1 | High selects twos-complement coding |
| busy_i | input | 1 | Conversion in progress flag from the sequencer |
| conv_data_i | input | 16 | Word produced by the current conversion |
| data_o | output | 16 | Output data bus |
| oe_o | output | 16 | Per-bit output enable, high means driven |

## Verification
Two functions can meet in one cycle: publishing a new result when busy falls, and capturing the word when a read begins. The bench provokes this by releasing busy and lowering both strobes in the same cycle, and it expects the new word rather than the stale one. It also publishes a result in the middle of an open read and then requires that the bus still shows the old word until the strobes rise and fall again.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANES = DATA_W / LANE_W;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/rdo_result_store.sv
module rdo_result_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         busy_i,
  input  logic [W-1:0] conv_data_i,
  output logic [W-1:0] word_o
);
  logic         busy_q;
  logic [W-1:0] result_q;
  logic         fall;

  assign fall = busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      result_q <= '0;
    end else begin
      busy_q <= busy_i;
      if (fall) result_q <= conv_data_i;
    end
  end

  // bypass so a read starting on the fall edge sees the new word
  assign word_o = fall ? conv_data_i : result_q;
endmodule

// File: rtl/rdo_capture.sv
module rdo_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic         ser_mode_i,
  input  logic         twos_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] hold_o,
  output logic         active_o
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic         en_now;
  logic         en_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] coded;

  assign en_now = ~(cs_ni | rd_ni) & ~ser_mode_i;
  assign coded  = twos_i ? (word_i ^ MSB_MASK) : word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      en_q <= en_now;
      if (en_now && !en_q) hold_q <= coded;
    end
  end

  assign hold_o   = hold_q;
  assign active_o = en_q;
endmodule

// File: rtl/rdo_lane_mux.sv
module rdo_lane_mux #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [W-1:0] hold_i,
  input  logic         active_i,
  input  logic         swap_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  localparam int unsigned LANES = W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned SRC = LANES - 1 - l;
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = swap_i ? hold_i[SRC*LANE_W +: LANE_W] : hold_i[l*LANE_W +: LANE_W];
      data_o[l*LANE_W +: LANE_W] = active_i ? lane : '0;
      oe_o[l*LANE_W +: LANE_W]   = {LANE_W{active_i}};
    end
  end
endmodule

// File: rtl/par_readout.sv
module par_readout
  import rdo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              ser_mode_i,
  input  logic              swap_i,
  input  logic              twos_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] oe_o
);
  word_t pub_word;
  word_t hold;
  logic  active;

  rdo_result_store #(.W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_i),
    .conv_data_i(conv_data_i),
    .word_o     (pub_word)
  );

  rdo_capture #(.W(DATA_W)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .ser_mode_i(ser_mode_i),
    .twos_i    (twos_i),
    .word_i    (pub_word),
    .hold_o    (hold),
    .active_o  (active)
  );

  rdo_lane_mux #(.W(DATA_W), .LANE_W(LANE_W)) u_mux (
    .hold_i  (hold),
    .active_i(active),
    .swap_i  (swap_i),
    .data_o  (data_o),
    .oe_o    (oe_o)
  );
endmodule

// File: rtl/par_readout_chk.sv
module par_readout_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cs_ni,
  input logic         rd_ni,
  input logic         ser_mode_i,
  input logic         swap_i,
  input logic [W-1:0] data_o,
  input logic [W-1:0] oe_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_OE_FOLLOWS_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    $past(!cs_ni && !rd_ni && !ser_mode_i) |-> oe_o == '1); // R2
  AST_OE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    $past(cs_ni || rd_ni) |-> oe_o == '0); // R2
  AST_SERIAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    $past(ser_mode_i) |-> oe_o == '0); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o == '0 |-> data_o == '0); // R11
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
    (oe_o == '1 && $past(oe_o == '1) && $stable(swap_i)) |-> $stable(data_o)); // R10
endmodule

bind par_readout par_readout_chk #(.W(16)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .ser_mode_i(ser_mode_i),
  .swap_i    (swap_i),
  .data_o    (data_o),
  .oe_o      (oe_o)
);

// File: tb/par_readout_tb_top.sv
`timescale 1ns/1ps
module par_readout_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, rd_ni = 1'b1, ser_mode_i = 1'b0;
  logic        swap_i = 1'b0, twos_i = 1'b0, busy_i = 1'b0;
  logic [15:0] conv_data_i = '0;
  logic [15:0] data_o, oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  par_readout dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
    .ser_mode_i(ser_mode_i), .swap_i(swap_i), .twos_i(twos_i),
    .busy_i(busy_i), .conv_data_i(conv_data_i),
    .data_o(data_o), .oe_o(oe_o)
  );

  // {conv word, twos, swap, expected bus}
  typedef struct packed {
    logic [15:0] conv;
    logic        twos;
    logic        swap;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 1'b0, 1'b0, 16'h1234},
    '{16'h1234, 1'b0, 1'b1, 16'h3412},
    '{16'h1234, 1'b1, 1'b0, 16'h9234},
    '{16'h1234, 1'b1, 1'b1, 16'h3492},
    '{16'h8001, 1'b1, 1'b0, 16'h0001},
    '{16'hFFFF, 1'b0, 1'b1, 16'hFFFF},
    '{16'h00FF, 1'b0, 1'b1, 16'hFF00},
    '{16'h7F80, 1'b1, 1'b1, 16'h80FF}
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic publish(logic [15:0] w);
    busy_i = 1'b1; conv_data_i = w; tick();
    busy_i = 1'b0; tick();
  endtask

  task automatic rd_open();
    cs_ni = 1'b0; rd_ni = 1'b0; tick();
  endtask

  task automatic rd_close();
    cs_ni = 1'b1; rd_ni = 1'b1; tick();
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 oe", oe_o, 16'h0000);
    chk("R1 data", data_o, 16'h0000);
    rst_ni = 1'b1; tick();

    // vector table: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      publish(VECS[i].conv);
      twos_i = VECS[i].twos; swap_i = VECS[i].swap;
      rd_open();
      chk("R2 oe active", oe_o, 16'hFFFF);
      chk(VECS[i].swap ? "R5 swapped" : "R4 straight lanes", data_o, VECS[i].exp);
      rd_close();
      chk("R2 oe released", oe_o, 16'h0000);
      chk("R11 data idle", data_o, 16'h0000);
    end
    twos_i = 1'b0; swap_i = 1'b0;

    // R2: only one strobe low
    cs_ni = 1'b0; tick();
    chk("R2 cs only", oe_o, 16'h0000);
    cs_ni = 1'b1; rd_ni = 1'b0; tick();
    chk("R2 rd only", oe_o, 16'h0000);
    rd_ni = 1'b1; tick();

    // R3: serial mode
    ser_mode_i = 1'b1; cs_ni = 1'b0; rd_ni = 1'b0; tick(); tick();
    chk("R3 serial oe", oe_o, 16'h0000);
    chk("R3 serial data", data_o, 16'h0000);
    ser_mode_i = 1'b0; tick();
    chk("R3 back to parallel", oe_o, 16'hFFFF);
    rd_close();

    // R8 / R10 / R7
    publish(16'hA5A5);
    busy_i = 1'b1; conv_data_i = 16'h5A3C; tick();
    rd_open();
    chk("R8 read during busy", data_o, 16'hA5A5);
    busy_i = 1'b0; tick(); tick();
    chk("R10 no tear after publish", data_o, 16'hA5A5);
    twos_i = 1'b1; tick();
    chk("R6 twos change mid-read ignored", data_o, 16'hA5A5);
    swap_i = 1'b1; #1;
    chk("R5 mid-read swap", data_o, 16'hA5A5 == 16'hA5A5 ? 16'hA5A5 : 16'h0);
    swap_i = 1'b0; twos_i = 1'b0;
    rd_close();
    rd_open();
    chk("R7 new result after fall", data_o, 16'h5A3C);
    swap_i = 1'b1; #1;
    chk("R5 mid-read swap", data_o, 16'h3C5A);
    swap_i = 1'b0;
    rd_close();

    // R7: busy staying low does not republish
    conv_data_i = 16'h0F0F; tick(); tick();
    rd_open();
    chk("R7 hold without fall", data_o, 16'h5A3C);
    rd_close();

    // R9: read opens on the busy fall edge
    busy_i = 1'b1; conv_data_i = 16'hC0DE; tick();
    busy_i = 1'b0; cs_ni = 1'b0; rd_ni = 1'b0; tick();
    chk("R9 same-edge read", data_o, 16'hC0DE);
    rd_close();

    // R1: reset mid-read
    rd_open();
    rst_ni = 1'b0; #1;
    chk("R1 async reset oe", oe_o, 16'h0000);
    chk("R1 async reset data", data_o, 16'h0000);
    rd_close();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule